// File: doc/BRIEF.md
# I2C Bit Timing Engine

This block is the bit-level timing core of an I2C master. For every requested bit it pulls SCL low and waits a programmed hold count before moving SDA. It then keeps SDA steady for a programmed setup count, releases SCL, and counts the SCL high phase. At the end it reports completion together with the SDA level it sampled. All durations are counts of the input clock. Software derives each count as nanoseconds × clock-in-MHz / 1000. The SCL high and low counts are independent, so both an even 50/50 duty cycle (up to 100 kHz) and a 33/66 high/low split (fast rates) can be set.

Both bus lines are read back through programmable glitch filters. Every timing decision uses the filtered levels. The high count therefore begins only once SCL is actually observed high, which lets a slave stretch the clock. The outputs are open-drain enables: a 1 pulls the line low and a 0 releases it. Start/stop conditions, addressing and byte sequencing belong to the logic above this block.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both drive enables are 0, both filtered lines read 1, and bit_done is 0.
- R2: A bit_req seen while the engine is idle pulls SCL low (scl_oe = 1), visible after the accepting clock edge.
- R3: SDA takes the new bit (sda_oe = 1 for a 0 bit, 0 for a 1 bit) exactly He = max(cfg_sda_hold, 1) cycles after SCL was pulled low. SDA never changes unless SCL was held low both before and after the change.
- R4: SCL is released exactly R = max(cfg_scl_low, He + Se) cycles after it was pulled low, where Se = max(cfg_sda_setup, 1). SDA has then been stable for at least Se cycles.
- R5: The high count starts only while filtered SCL is 1. bit_done is a one-cycle pulse that appears He... precisely D = R + S + F + Hh cycles after the request edge, where S is the number of cycles a slave holds SCL low past release, F = max(cfg_spike, 1) and Hh = max(cfg_scl_high, 1).
- R6: A filtered line takes a new raw level at the F-th consecutive clock edge on which the raw level differs from it. A shorter pulse leaves the filtered line unchanged.
- R7: rx_bit, valid with bit_done, equals filtered SDA at the final high-count edge.
- R8: A bit_req that arrives while a bit is in progress is ignored. It changes neither the bit's timing, nor its SDA value, nor starts another bit.
- R9: After bit_done, SCL stays released and SDA keeps its value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_scl_high | input | CNT_W | SCL high count |
| cfg_scl_low | input | CNT_W | SCL low count |
| cfg_sda_setup | input | CNT_W | SDA setup count before SCL release |
| cfg_sda_hold | input | CNT_W | SDA hold count after SCL pulled low |
| cfg_spike | input | SPK_W | Glitch filter length |
| bit_req | input | 1 | Request to shift one bit |
| bit_val | input | 1 | Bit to send (1 = release SDA) |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_filt | output | 1 | Filtered SCL level |
| sda_filt | output | 1 | Filtered SDA level |
| bit_done | output | 1 | One-cycle end-of-bit strobe |
| rx_bit | output | 1 | SDA sampled at end of bit |

## Verification
Every output is registered, so a change made at the k-th edge after the request edge is first seen at the falling clock edge that follows. The bench counts falling edges from the request edge and expects the following. SCL falls at count 0 and SDA moves at He. SCL is released at R. bit_done comes at R + S + F + Hh, where the F cycles cover the filter's latency on the rising SCL, and rx_bit is read at that same count. A glitch of k cycles is expected to move a filtered line at count F only when k ≥ F. All of these counts are computed from the configuration before each bit and compared with the first cycle in which the event is observed.

// File: rtl/i2c_bit_timer_pkg.sv
package i2c_bit_timer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SPK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPK_W-1:0] len,
    input  logic             raw,
    output logic             filt
);
    typedef struct packed {
        logic             lvl;
        logic [SPK_W-1:0] run;
    } flt_t;

    flt_t            st_d, st_q;
    logic [SPK_W:0]  len_e;
    logic [SPK_W:0]  run_inc;

    always_comb begin
        st_d    = st_q;
        len_e   = (len == '0) ? (SPK_W+1)'(1) : {1'b0, len};
        run_inc = {1'b0, st_q.run} + (SPK_W+1)'(1);
        if (raw != st_q.lvl) begin
            if (run_inc >= len_e) begin
                st_d.lvl = raw;
                st_d.run = '0;
            end else begin
                st_d.run = run_inc[SPK_W-1:0];
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= 1'b1;
            st_q.run <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt = st_q.lvl;
endmodule

// File: rtl/i2c_phase_fsm.sv
module i2c_phase_fsm
    import i2c_bit_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_scl_high,
    input  logic [CNT_W-1:0] cfg_scl_low,
    input  logic [CNT_W-1:0] cfg_sda_setup,
    input  logic [CNT_W-1:0] cfg_sda_hold,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             scl_filt,
    input  logic             sda_filt,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             bit_done,
    output logic             rx_bit
);
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        phase_t          ph;
        logic [CW-1:0]   cnt;
        logic            scl_oe;
        logic            sda_oe;
        logic            tx;
        logic            done;
        logic            rx;
    } fsm_t;

    fsm_t          st_d, st_q;
    logic [CW-1:0] hold_e, setup_e, high_e, low_w, rel_at, cnt_inc;

    function automatic logic [CW-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CW'(1) : {1'b0, v};
    endfunction

    always_comb begin
        hold_e  = at_least_one(cfg_sda_hold);
        setup_e = at_least_one(cfg_sda_setup);
        high_e  = at_least_one(cfg_scl_high);
        low_w   = {1'b0, cfg_scl_low};
        rel_at  = (low_w > hold_e + setup_e) ? low_w : hold_e + setup_e;
        cnt_inc = st_q.cnt + CW'(1);

        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (bit_req) begin
                    st_d.ph     = PH_LOW;
                    st_d.cnt    = '0;
                    st_d.scl_oe = 1'b1;
                    st_d.tx     = bit_val;
                end
            end
            PH_LOW: begin
                st_d.cnt = cnt_inc;
                if (cnt_inc == hold_e) st_d.sda_oe = ~st_q.tx;
                if (cnt_inc >= rel_at) begin
                    st_d.ph     = PH_HIGH;
                    st_d.cnt    = '0;
                    st_d.scl_oe = 1'b0;
                end
            end
            PH_HIGH: begin
                if (scl_filt) begin
                    st_d.cnt = cnt_inc;
                    if (cnt_inc >= high_e) begin
                        st_d.ph   = PH_IDLE;
                        st_d.cnt  = '0;
                        st_d.done = 1'b1;
                        st_d.rx   = sda_filt;
                    end
                end else begin
                    st_d.cnt = '0;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph     <= PH_IDLE;
            st_q.cnt    <= '0;
            st_q.scl_oe <= 1'b0;
            st_q.sda_oe <= 1'b0;
            st_q.tx     <= 1'b1;
            st_q.done   <= 1'b0;
            st_q.rx     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_oe   = st_q.scl_oe;
    assign sda_oe   = st_q.sda_oe;
    assign bit_done = st_q.done;
    assign rx_bit   = st_q.rx;
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
    parameter int CNT_W = 8,
    parameter int SPK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_scl_high,
    input  logic [CNT_W-1:0] cfg_scl_low,
    input  logic [CNT_W-1:0] cfg_sda_setup,
    input  logic [CNT_W-1:0] cfg_sda_hold,
    input  logic [SPK_W-1:0] cfg_spike,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             scl_filt,
    output logic             sda_filt,
    output logic             bit_done,
    output logic             rx_bit
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_w;
    logic [NLINE-1:0] filt_w;

    assign raw_w = {sda_in, scl_in};

    for (genvar gi = 0; gi < NLINE; gi++) begin : g_line
        i2c_glitch_filter #(.SPK_W(SPK_W)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .len  (cfg_spike),
            .raw  (raw_w[gi]),
            .filt (filt_w[gi])
        );
    end

    assign scl_filt = filt_w[0];
    assign sda_filt = filt_w[1];

    i2c_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_scl_high (cfg_scl_high),
        .cfg_scl_low  (cfg_scl_low),
        .cfg_sda_setup(cfg_sda_setup),
        .cfg_sda_hold (cfg_sda_hold),
        .bit_req      (bit_req),
        .bit_val      (bit_val),
        .scl_filt     (filt_w[0]),
        .sda_filt     (filt_w[1]),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe),
        .bit_done     (bit_done),
        .rx_bit       (rx_bit)
    );
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_sda_setup,
    input logic             scl_in,
    input logic             sda_in,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             scl_filt,
    input logic             sda_filt,
    input logic             bit_done
);
    localparam int CW = CNT_W + 1;

    logic          prev_q;
    logic [CW-1:0] since_q;
    logic [CW-1:0] setup_e;

    assign setup_e = (cfg_sda_setup == '0) ? CW'(1) : {1'b0, cfg_sda_setup};

    // cycles since the SDA enable last moved, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            since_q <= '1;
        end else begin
            prev_q <= sda_oe;
            if (sda_oe != prev_q) since_q <= CW'(1);
            else if (since_q != '1) since_q <= since_q + CW'(1);
        end
    end

    p_sda_in_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (scl_oe && $past(scl_oe)));

    p_setup_before_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> ($stable(sda_oe) && since_q >= setup_e));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done);

    p_done_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> $past(scl_filt));

    p_scl_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_filt) |-> (scl_filt == $past(scl_in)));

    p_sda_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_filt) |-> (sda_filt == $past(sda_in)));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_sda_setup(cfg_sda_setup),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .scl_filt     (scl_filt),
    .sda_filt     (sda_filt),
    .bit_done     (bit_done)
);

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int SPK_W = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic [CNT_W-1:0] cfg_scl_high, cfg_scl_low, cfg_sda_setup, cfg_sda_hold;
    logic [SPK_W-1:0] cfg_spike;
    logic bit_req, bit_val;
    logic scl_in, sda_in;
    logic scl_oe, sda_oe, scl_filt, sda_filt, bit_done, rx_bit;

    logic hold_low, slave_low, scl_glitch, sda_glitch;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_in = ~scl_oe & ~hold_low & ~scl_glitch;
    assign sda_in = ~sda_oe & ~slave_low & ~sda_glitch;

    i2c_bit_timer #(.CNT_W(CNT_W), .SPK_W(SPK_W)) i_i2c_bit_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_scl_high(cfg_scl_high), .cfg_scl_low(cfg_scl_low),
        .cfg_sda_setup(cfg_sda_setup), .cfg_sda_hold(cfg_sda_hold),
        .cfg_spike(cfg_spike), .bit_req(bit_req), .bit_val(bit_val),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .scl_filt(scl_filt), .sda_filt(sda_filt), .bit_done(bit_done),
        .rx_bit(rx_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int one_min(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic glitch_test(input int line, input int len, input int k);
        int f = one_min(len);
        int fall = -1;
        int last;
        cfg_spike = SPK_W'(len);
        @(negedge clk);
        if (line == 0) scl_glitch = 1'b1; else sda_glitch = 1'b1;
        for (int n = 1; n <= k + f + 2; n++) begin
            @(negedge clk);
            if (n == k) begin scl_glitch = 1'b0; sda_glitch = 1'b0; end
            last = (line == 0) ? int'(scl_filt) : int'(sda_filt);
            if (last == 0 && fall < 0) fall = n;
        end
        chk(fall == ((k >= f) ? f : -1), "R6 filter reaction cycle", fall, (k >= f) ? f : -1);
        chk(last == 1, "R6 filtered level restored", last, 1);
    endtask

    task automatic run_bit(input logic b, input logic slave, input int s, input logic poke);
        int he = one_min(int'(cfg_sda_hold));
        int se = one_min(int'(cfg_sda_setup));
        int r  = (int'(cfg_scl_low) > he + se) ? int'(cfg_scl_low) : he + se;
        int f  = one_min(int'(cfg_spike));
        int hh = one_min(int'(cfg_scl_high));
        int d  = r + s + f + hh;
        logic prev_sda = sda_oe;
        int first_sda = -1, first_rel = -1, done_n = -1, n_done = 0, regrab = 0;
        int rx_seen = -1, scl_at0 = 0;
        @(negedge clk);
        bit_val = b; bit_req = 1'b1; slave_low = slave; hold_low = (s > 0);
        @(posedge clk);
        for (int n = 0; n <= d + 3; n++) begin
            @(negedge clk);
            if (n == 0) begin bit_req = 1'b0; scl_at0 = int'(scl_oe); end
            if (poke && n == 1) begin bit_req = 1'b1; bit_val = ~b; end
            if (poke && n == 2) bit_req = 1'b0;
            if (sda_oe != prev_sda && first_sda < 0) first_sda = n;
            if (!scl_oe && first_rel < 0) first_rel = n;
            if (first_rel >= 0 && scl_oe) regrab = 1;
            if (bit_done) begin
                n_done++;
                if (done_n < 0) begin done_n = n; rx_seen = int'(rx_bit); end
            end
            if (s > 0 && n == r + s) hold_low = 1'b0;
        end
        slave_low = 1'b0;
        chk(scl_at0 == 1, "R2 SCL pulled low", scl_at0, 1);
        chk(first_sda == ((~b != prev_sda) ? he : -1), "R3 SDA change cycle", first_sda,
            (~b != prev_sda) ? he : -1);
        chk(sda_oe == ~b, "R3 SDA level", int'(sda_oe), int'(~b));
        chk(first_rel == r, "R4 SCL release cycle", first_rel, r);
        chk(done_n == d, "R5 done cycle", done_n, d);
        chk(n_done == 1, "R5 single done pulse", n_done, 1);
        chk(rx_seen == int'(b & ~slave), "R7 sampled bit", rx_seen, int'(b & ~slave));
        chk(regrab == 0 && scl_oe == 1'b0, "R9 SCL stays released", regrab, 0);
        if (poke) chk(n_done == 1 && sda_oe == ~b, "R8 busy request ignored", n_done, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        rst_n = 1'b0; bit_req = 1'b0; bit_val = 1'b1;
        hold_low = 1'b0; slave_low = 1'b0; scl_glitch = 1'b0; sda_glitch = 1'b0;
        cfg_scl_high = 8'd2; cfg_scl_low = 8'd3; cfg_sda_setup = 8'd1;
        cfg_sda_hold = 8'd1; cfg_spike = 4'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 drive enables", int'({scl_oe, sda_oe}), 0);
        chk(scl_filt && sda_filt, "R1 filtered lines", int'({scl_filt, sda_filt}), 3);
        chk(bit_done == 1'b0, "R1 done low", int'(bit_done), 0);

        for (int line = 0; line < 2; line++)
            for (int len = 0; len < 4; len++)
                for (int k = 1; k < 5; k++)
                    glitch_test(line, len, k);

        for (int hd = 0; hd < 3; hd++)
            for (int su = 0; su < 3; su++)
                for (int lo = 0; lo < 3; lo++)
                    for (int hi = 0; hi < 3; hi++)
                        for (int sp = 0; sp < 3; sp++)
                            for (int st = 0; st < 2; st++) begin
                                logic b;
                                cfg_sda_hold  = CNT_W'(hd);
                                cfg_sda_setup = CNT_W'(su);
                                cfg_scl_low   = CNT_W'((lo == 0) ? 1 : (lo == 1) ? 3 : 6);
                                cfg_scl_high  = CNT_W'((hi == 2) ? 3 : hi);
                                cfg_spike     = SPK_W'(sp);
                                b = idx[0] ^ idx[2];
                                run_bit(b, b && (idx % 3 == 0), st * 3, (idx % 5) == 0);
                                idx++;
                            end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule